// File: doc/BRIEF.md
# Dual-Width Host Register Port

This block is the host-facing register port of a character display controller. A host drives a register-select line, a read/write line, an enable strobe and an 8-bit data bus. The port samples these asynchronous lines into the core clock domain and detects the falling edge of enable. On a write, it hands the core one single-cycle strobe that carries the full byte and an instruction-or-data flag. On a read, it returns either the status byte or RAM data from the core.

The bus can run at two widths. In wide mode all eight lines carry a byte per enable pulse. In narrow mode only the upper four lines are used, and each byte takes two pulses, upper half first. The port tracks which half comes next, for writes and for reads alike. The width is selected at run time: an instruction byte of the form `001w_xxxx` is a mode-set command, and its bit 4 (`w`) picks the width. The port decodes only this one command. All other decoding is left to the core.

Top module: `hostbus_port`

## Requirements
- R1: After a synchronous reset the port is in wide mode, raises no strobe and drives `bus_dout` to zero.
- R2: In wide mode each falling edge of `bus_en` with `bus_rw`=0 yields exactly one single-cycle `wr_stb`. It carries `bus_din` as `wr_byte`, and `wr_is_data` equals `bus_rs`.
- R3: In narrow mode two write pulses yield one `wr_stb` whose byte is {first `bus_din[7:4]`, second `bus_din[7:4]`}. No strobe follows the first pulse, and `bus_din[3:0]` is ignored.
- R4: A completed instruction byte (`bus_rs`=0) whose bits 7..5 are 001 sets `wide_mode` to its bit 4, from the next transfer on. A data byte with the same pattern leaves the width unchanged.
- R5: The half-byte phase starts at the upper half after reset and after any width change. The first narrow pulse after a switch to narrow mode is therefore always an upper half.
- R6: In wide mode, while `bus_en` is high with `bus_rw`=1, `bus_dout` shows `core_rdata` when `bus_rs`=1. When `bus_rs`=0 it shows the status byte {`core_busy`, `core_addr`}, with the busy flag in bit 7.
- R7: In narrow mode a read returns the selected byte's bits 7..4 on `bus_dout[7:4]` during the first pulse and bits 3..0 there during the second. `bus_dout[3:0]` stays zero.
- R8: `rd_stb` pulses once per completed data read (`bus_rs`=1): after every pulse in wide mode, after every second pulse in narrow mode. It never pulses for status reads.
- R9: Three writes of the start-up pattern (upper lines 0011, lower lines 0) leave the port in wide mode, whether it started in wide or narrow mode.
- R10: `bus_dout` is zero whenever `bus_en` is low or the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Host enable strobe, asynchronous |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 RAM data |
| bus_rw | input | 1 | 0 write, 1 read |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Read data returned to the host |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Address counter from the core |
| core_rdata | input | 8 | RAM read data from the core |
| wr_stb | output | 1 | One-cycle write strobe for a completed byte |
| wr_is_data | output | 1 | Strobe target: 1 data, 0 instruction |
| wr_byte | output | 8 | Completed write byte |
| rd_stb | output | 1 | One-cycle pulse after a completed data read |
| wide_mode | output | 1 | Current bus width: 1 eight lines, 0 four lines |

## Verification
A mode-set byte completes, emits its write strobe, changes the width and re-arms the half-byte phase, all on the same clock edge. The bench provokes this by sending the pair 0x3/0x3 while in narrow mode. It judges the result by checking that the following single pulse is accepted as a whole byte. The opposite direction is also exercised: switching to narrow mode from wide mode, after which the very next pulse must land as an upper half. It is also checked that a data-register write with the mode-set pattern leaves the width untouched.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int BUS_W   = 8;
  localparam int NIB_W   = BUS_W / 2;
  localparam int ADDR_W  = BUS_W - 1;
  localparam int TAG_W   = 3;
  localparam logic [TAG_W-1:0] MSET_TAG = 3'b001;
  localparam int MSET_WIDTH_BIT = 4;

  typedef struct packed {
    logic             en;
    logic             rs;
    logic             rw;
    logic [BUS_W-1:0] db;
  } bus_sample_t;

  localparam int SAMPLE_W = $bits(bus_sample_t);
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) st[i] <= st[i-1];
      st[0] <= d;
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbp_nibble_ctl.sv
module hbp_nibble_ctl
  import hbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             rs,
  input  logic             rw,
  input  logic [BUS_W-1:0] din,
  output logic             wide,
  output logic             phase,
  output logic             wr_stb,
  output logic             wr_is_data,
  output logic [BUS_W-1:0] wr_byte,
  output logic             rd_stb
);
  logic [NIB_W-1:0] hi_q;
  logic [BUS_W-1:0] full_byte;
  logic             byte_done;
  logic             is_mset;
  logic             rd_done;

  // completion of a byte: wide mode every pulse, narrow mode the low half
  assign full_byte = wide ? din : {hi_q, din[BUS_W-1 -: NIB_W]};
  assign byte_done = fall & ~rw & (wide | phase);
  assign rd_done   = fall & rw & (wide | phase);
  assign is_mset   = ~rs & (full_byte[BUS_W-1 -: TAG_W] == MSET_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide       <= 1'b1;
      phase      <= 1'b0;
      hi_q       <= '0;
      wr_stb     <= 1'b0;
      wr_is_data <= 1'b0;
      wr_byte    <= '0;
      rd_stb     <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (fall && !wide && !phase) begin
        phase <= 1'b1;
        if (!rw) hi_q <= din[BUS_W-1 -: NIB_W];
      end
      if (rd_done) begin
        phase  <= 1'b0;
        rd_stb <= rs;
      end
      if (byte_done) begin
        phase      <= 1'b0;
        wr_stb     <= 1'b1;
        wr_byte    <= full_byte;
        wr_is_data <= rs;
        if (is_mset) wide <= full_byte[MSET_WIDTH_BIT];
      end
    end
  end
endmodule

// File: rtl/hbp_read_mux.sv
module hbp_read_mux
  import hbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_hi,
  input  logic              rs,
  input  logic              rw,
  input  logic              wide,
  input  logic              phase,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  dout
);
  logic [BUS_W-1:0] sel;
  logic [BUS_W-1:0] shaped;
  logic [NIB_W-1:0] half;

  assign sel = rs ? rdata : {busy, addr};

  // pick the half for narrow mode: lane 1 holds bits 7..4, lane 0 bits 3..0
  for (genvar b = 0; b < NIB_W; b++) begin : g_half
    assign half[b] = phase ? sel[b] : sel[b + NIB_W];
  end

  assign shaped = wide ? sel : {half, {NIB_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (en_hi && rw) dout <= shaped;
    else dout <= '0;
  end
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout,
  input  logic              core_busy,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [BUS_W-1:0]  core_rdata,
  output logic              wr_stb,
  output logic              wr_is_data,
  output logic [BUS_W-1:0]  wr_byte,
  output logic              rd_stb,
  output logic              wide_mode
);
  bus_sample_t raw, synced;
  logic        en_q;
  logic        fall;
  logic        phase;

  assign raw = '{en: bus_en, rs: bus_rs, rw: bus_rw, db: bus_din};

  hbp_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= synced.en;
  end

  assign fall = en_q & ~synced.en;

  hbp_nibble_ctl u_ctl (
    .clk(clk), .rst(rst), .fall(fall),
    .rs(synced.rs), .rw(synced.rw), .din(synced.db),
    .wide(wide_mode), .phase(phase),
    .wr_stb(wr_stb), .wr_is_data(wr_is_data), .wr_byte(wr_byte),
    .rd_stb(rd_stb)
  );

  hbp_read_mux u_rd (
    .clk(clk), .rst(rst), .en_hi(synced.en),
    .rs(synced.rs), .rw(synced.rw),
    .wide(wide_mode), .phase(phase),
    .busy(core_busy), .addr(core_addr), .rdata(core_rdata),
    .dout(bus_dout)
  );
endmodule

// File: rtl/hbp_checks.sv
module hbp_checks
  import hbp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             wr_is_data,
  input logic [BUS_W-1:0] wr_byte,
  input logic             rd_stb,
  input logic             wide_mode,
  input logic [BUS_W-1:0] bus_dout
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wide_mode && !wr_stb && !rd_stb && bus_dout == '0));

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_stb}));

  assert_wr_single_R2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_rd_single_R8: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb);

  assert_width_by_mset_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(wide_mode) |-> (wr_stb && !wr_is_data &&
      wr_byte[BUS_W-1 -: TAG_W] == MSET_TAG &&
      wr_byte[MSET_WIDTH_BIT] == wide_mode));

  assert_narrow_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && !$past(wide_mode)) |-> bus_dout[NIB_W-1:0] == '0);
endmodule

bind hostbus_port hbp_checks u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_is_data(wr_is_data),
  .wr_byte(wr_byte), .rd_stb(rd_stb), .wide_mode(wide_mode),
  .bus_dout(bus_dout)
);

// File: tb/hostbus_port_test.sv
module hostbus_port_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       core_busy = 1'b0;
  logic [6:0] core_addr = '0;
  logic [7:0] core_rdata = '0;
  logic       wr_stb, wr_is_data, rd_stb, wide_mode;
  logic [7:0] wr_byte;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_wr = '0;
  logic       last_is_data = 1'b0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hostbus_port uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .core_busy(core_busy),
    .core_addr(core_addr), .core_rdata(core_rdata), .wr_stb(wr_stb),
    .wr_is_data(wr_is_data), .wr_byte(wr_byte), .rd_stb(rd_stb),
    .wide_mode(wide_mode)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        wr_cnt++;
        last_wr = wr_byte;
        last_is_data = wr_is_data;
      end
      if (rd_stb) rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic rs, input logic [7:0] d);
    bus_rs = rs; bus_rw = 1'b0; bus_din = d;
    repeat (2) @(negedge clk);
    bus_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic rs, output logic [7:0] d);
    bus_rs = rs; bus_rw = 1'b1;
    repeat (2) @(negedge clk);
    bus_en = 1'b1;
    repeat (5) @(negedge clk);
    d = bus_dout;
    bus_en = 1'b0;
    repeat (6) @(negedge clk);
    bus_rw = 1'b0;
  endtask

  task automatic t_reset();
    check(wide_mode == 1'b1, "R1 wide after reset", wide_mode, 1);
    check(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", wr_cnt + rd_cnt, 0);
    check(bus_dout == 8'h00, "R1 dout zero", bus_dout, 0);
  endtask

  task automatic t_write8();
    int n = wr_cnt;
    bus_write(1'b1, 8'hA5);
    check(wr_cnt == n + 1, "R2 one strobe", wr_cnt - n, 1);
    check(last_wr == 8'hA5 && last_is_data, "R2 data byte", {last_is_data, last_wr}, 9'h1A5);
    bus_write(1'b0, 8'h0C);
    check(last_wr == 8'h0C && !last_is_data, "R2 instr byte", {last_is_data, last_wr}, 9'h00C);
    check(wr_cnt == n + 2, "R2 count", wr_cnt - n, 2);
  endtask

  task automatic t_read8();
    logic [7:0] d;
    int n = rd_cnt;
    core_busy = 1'b1; core_addr = 7'h2B; core_rdata = 8'h5E;
    bus_read(1'b0, d);
    check(d == 8'hAB, "R6 status byte", d, 8'hAB);
    check(rd_cnt == n, "R8 no pulse on status", rd_cnt - n, 0);
    bus_read(1'b1, d);
    check(d == 8'h5E, "R6 data byte", d, 8'h5E);
    check(rd_cnt == n + 1, "R8 pulse per byte wide", rd_cnt - n, 1);
    check(bus_dout == 8'h00, "R10 idle dout", bus_dout, 0);
    bus_rw = 1'b0; bus_rs = 1'b1;
    bus_en = 1'b1;
    repeat (5) @(negedge clk);
    check(bus_dout == 8'h00, "R10 dout zero during write", bus_dout, 0);
    bus_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_mode_switch();
    bus_write(1'b1, 8'h20);
    check(wide_mode == 1'b1, "R4 data pattern ignored", wide_mode, 1);
    bus_write(1'b0, 8'h28);
    check(wide_mode == 1'b0, "R4 switch to narrow", wide_mode, 0);
  endtask

  task automatic t_write4();
    int n = wr_cnt;
    bus_write(1'b1, 8'h40);
    check(wr_cnt == n, "R3 no strobe after first half", wr_cnt - n, 0);
    bus_write(1'b1, 8'h70);
    check(last_wr == 8'h47 && wr_cnt == n + 1, "R5 R3 assembled byte", last_wr, 8'h47);
    bus_write(1'b0, 8'h9F);
    bus_write(1'b0, 8'h3F);
    check(last_wr == 8'h93 && !last_is_data, "R3 low lines ignored", last_wr, 8'h93);
  endtask

  task automatic t_read4();
    logic [7:0] d;
    int n = rd_cnt;
    core_busy = 1'b0; core_addr = 7'h35; core_rdata = 8'hC6;
    bus_read(1'b0, d);
    check(d == 8'h30, "R7 status upper half", d, 8'h30);
    bus_read(1'b0, d);
    check(d == 8'h50, "R7 status lower half", d, 8'h50);
    check(rd_cnt == n, "R8 no pulse on narrow status", rd_cnt - n, 0);
    bus_read(1'b1, d);
    check(d == 8'hC0 && rd_cnt == n, "R7 R8 data upper half", d, 8'hC0);
    bus_read(1'b1, d);
    check(d == 8'h60, "R7 data lower half", d, 8'h60);
    check(rd_cnt == n + 1, "R8 pulse after second half", rd_cnt - n, 1);
  endtask

  task automatic t_startup_narrow();
    int n = wr_cnt;
    bus_write(1'b0, 8'h30);
    bus_write(1'b0, 8'h30);
    check(wide_mode == 1'b1 && last_wr == 8'h33, "R9 pair restores wide", wide_mode, 1);
    bus_write(1'b0, 8'h30);
    check(wide_mode == 1'b1 && wr_cnt == n + 2, "R9 third write whole byte", wr_cnt - n, 2);
    bus_write(1'b1, 8'hB4);
    check(last_wr == 8'hB4 && wr_cnt == n + 3, "R5 phase rearmed", last_wr, 8'hB4);
  endtask

  task automatic t_startup_wide();
    int n = wr_cnt;
    for (int i = 0; i < 3; i++) bus_write(1'b0, 8'h30);
    check(wide_mode == 1'b1 && wr_cnt == n + 3, "R9 wide start-up", wr_cnt - n, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write8();
    t_read8();
    t_startup_wide();
    t_mode_switch();
    t_write4();
    t_read4();
    t_startup_narrow();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule